// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block moves 8-bit characters over a three-wire link: a serial clock, a transmit data line and a receive data line. A character has no start, stop, parity or address bit. The transmitter launches each bit on a falling edge of the serial clock. The receiver captures each bit on a rising edge. Both directions send and receive the least significant bit first. The two directions run from the same serial clock but keep separate state, so the block runs full duplex.

The serial clock can come from two places. In internal mode a programmable divider of the system clock makes it, and the block drives it out. In external mode a partner device supplies it, and the block synchronizes it into the system clock domain. Each direction has a one-byte holding register in front of its shift register. The host can queue the next byte or collect the last one while a character is still shifting, so characters can follow one another with no gap.

In internal mode the clock runs only while the transmitter has something to send. To receive without sending useful data, the host transmits filler bytes.

Top module: `sync_serial_xcvr`

## Requirements
- R1: `txd` changes only when the serial clock falls, and each bit is held until the next falling edge.
- R2: The receiver samples `rxd` on each rising edge of the serial clock. After eight rising edges the byte is complete, with the first sampled bit in bit 0. `rx_data` then shows the byte and `rx_full` goes to 1.
- R3: A character is exactly eight bits, sent bit 0 first and bit 7 last, with no framing or parity bits. In internal mode this gives exactly eight clock pulses per character.
- R4: `txd` is 1 after reset. After a character ends, `txd` holds the level of bit 7 of that character until the next character starts.
- R5: With `clk_mode` = 00 or 01 (internal mode):
  - `sck_oe` is 1 and `sck_o` carries the serial clock.
  - Each low phase and each high phase lasts `div_cfg`+1 system clock cycles.
  - `sck_o` rests at 1 while there is nothing to send.
- R6: With `clk_mode` = 10 or 11 (external mode):
  - `sck_oe` is 0.
  - Falling and rising edges of `sck_i` drive both directions after a two-flop synchronizer.
- R7: `tx_empty` goes to 0 on a `tx_wr` pulse. It returns to 1 when that byte moves into the shift register at the next falling edge. A `tx_wr` pulse while `tx_empty` is 0 has no effect.
- R8: If a byte is waiting when a character ends, the next character starts at the falling edge that closes the normal high phase. The high phase between the two characters is `div_cfg`+1 cycles, with no extra idle clock period.
- R9: A `rx_rd` pulse clears `rx_full` and `rx_overrun`. If a byte completes while `rx_full` is 1 and `rx_rd` is not pulsed, the buffered byte is kept, the new byte is dropped and `rx_overrun` goes to 1.
- R10: Transmit and receive run at the same time from the one clock. With `txd` looped back to `rxd`, each sent byte is received unchanged.
- R11: After reset:
  - `tx_empty` = 1, `rx_full` = 0 and `rx_overrun` = 0.
  - `sck_o` = 1.
  - `txd` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_mode | input | 2 | Clock source: 0x internal divider, 1x external clock |
| div_cfg | input | DIV_W | Serial clock half period minus one, in system clock cycles |
| sck_i | input | 1 | External serial clock input |
| sck_o | output | 1 | Serial clock output (internal mode) |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| tx_wr | input | 1 | Write pulse for the transmit holding register |
| tx_data | input | DATA_W | Byte to transmit |
| tx_empty | output | 1 | Transmit holding register can accept a byte |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| rx_rd | input | 1 | Read acknowledge pulse for the receive buffer |
| rx_data | output | DATA_W | Last byte received |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_overrun | output | 1 | A byte was lost because the buffer was unread |

## Verification
**Internal mode timing.**
- A `tx_wr` pulse registers on the next edge.
- The first falling clock edge and the load into the shift register come one edge later.
- After that, each clock phase lasts `div_cfg`+1 cycles.
- `rx_full` rises on the same edge as the eighth rising clock edge.

**External mode timing.** Each `sck_i` edge reaches the logic three system cycles later. The bench therefore holds each external clock phase for six cycles and samples `txd` and the receive flags at the end of that phase.

**Bench practice.**
- Every input is driven, and every output sampled, one time unit after the falling system clock edge.
- A monitor measures the phase lengths and the bit order from the observed `sck_o` transitions.
- Every wait for a result has a bound on its length.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

  // Serial clock edge strobes, one system cycle wide.
  typedef struct packed {
    logic fall;
    logic rise;
  } ssx_edges_t;

  // Clock source selection: 2'b0x internal divider, 2'b1x external pin.
  function automatic logic ssx_is_ext(input logic [1:0] mode);
    return (mode == 2'b10) || (mode == 2'b11);
  endfunction

endpackage

// File: rtl/ssx_clkgen.sv
module ssx_clkgen
  import ssx_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_sel,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             need,
  input  logic             sck_i,
  output ssx_edges_t       edges,
  output logic             sck_o,
  output logic             sck_oe
);

  // Internal divider state
  logic             sck_q;
  logic [DIV_W-1:0] cnt_q;
  logic             int_fall, int_rise;

  // External clock synchronizer and edge detector
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              ext_fall, ext_rise;

  assign int_fall = !ext_sel && sck_q && (cnt_q == '0) && need;
  assign int_rise = !ext_sel && !sck_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= 1'b1;
      cnt_q  <= '0;
      sck_oe <= 1'b1;
    end else begin
      sck_oe <= !ext_sel;
      if (int_fall || int_rise) begin
        sck_q <= !sck_q;
        cnt_q <= div_cfg;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], sck_i};
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  assign ext_fall = prev_q && !sync_q[SYNC_N-1];
  assign ext_rise = !prev_q && sync_q[SYNC_N-1];

  assign edges.fall = ext_sel ? ext_fall : int_fall;
  assign edges.rise = ext_sel ? ext_rise : int_rise;
  assign sck_o      = sck_q;

endmodule

// File: rtl/ssx_tx.sv
module ssx_tx
  import ssx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ssx_edges_t        edges,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              empty,
  output logic              need,
  output logic              txd
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] hold_q, shf_q;
  logic              full_q, act_q, txd_q;
  logic [CNT_W-1:0]  idx_q;
  logic              last;

  assign last = (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      shf_q  <= '0;
      full_q <= 1'b0;
      act_q  <= 1'b0;
      idx_q  <= '0;
      txd_q  <= 1'b1;
    end else begin
      if (wr && !full_q) begin
        hold_q <= wdata;
        full_q <= 1'b1;
      end
      if (edges.fall) begin
        if (act_q && !last) begin
          shf_q <= shf_q >> 1;
          txd_q <= shf_q[1];
          idx_q <= idx_q + 1'b1;
        end else if (full_q) begin
          shf_q  <= hold_q;
          txd_q  <= hold_q[0];
          idx_q  <= '0;
          act_q  <= 1'b1;
          full_q <= 1'b0;
        end
      end
      if (edges.rise && act_q && last)
        act_q <= 1'b0;
    end
  end

  assign empty = !full_q;
  assign need  = (act_q && !last) || full_q;
  assign txd   = txd_q;

  // R1
  txd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !edges.fall |=> $stable(txd_q));

  // R7
  empty_set_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(full_q) |-> $past(edges.fall));

endmodule

// File: rtl/ssx_rx.sv
module ssx_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              rxd,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic              overrun
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shf_q, buf_q, next_shf;
  logic [CNT_W-1:0]  idx_q;
  logic              full_q, ovr_q, done;

  assign next_shf = {rxd, shf_q[DATA_W-1:1]};
  assign done     = rise && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      shf_q  <= '0;
      buf_q  <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (rise) begin
        shf_q <= next_shf;
        idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      end
      if (rd) begin
        full_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (done) begin
        if (full_q && !rd) begin
          ovr_q <= 1'b1;
        end else begin
          buf_q  <= next_shf;
          full_q <= 1'b1;
        end
      end
    end
  end

  assign rdata   = buf_q;
  assign full    = full_q;
  assign overrun = ovr_q;

  // R2
  full_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(full_q) |-> $past(rise));

  // R9
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> $past(full_q));

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        clk_mode,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_empty,
  output logic              txd,
  input  logic              rxd,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_overrun
);

  ssx_edges_t edges;
  logic       ext_sel, tx_need;

  assign ext_sel = ssx_is_ext(clk_mode);

  ssx_clkgen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_clk (
    .clk(clk), .rst(rst), .ext_sel(ext_sel), .div_cfg(div_cfg),
    .need(tx_need), .sck_i(sck_i), .edges(edges),
    .sck_o(sck_o), .sck_oe(sck_oe)
  );

  ssx_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .edges(edges), .wr(tx_wr), .wdata(tx_data),
    .empty(tx_empty), .need(tx_need), .txd(txd)
  );

  ssx_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .rise(edges.rise), .rxd(rxd), .rd(rx_rd),
    .rdata(rx_data), .full(rx_full), .overrun(rx_overrun)
  );

  // R5
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!ext_sel && sck_o && !tx_need) |=> sck_o);

endmodule

// File: tb/sync_serial_xcvr_test.sv
module sync_serial_xcvr_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic [1:0] clk_mode = 2'b00;
  logic [7:0] div_cfg = 8'd0;
  logic       sck_i = 1'b1;
  logic       sck_o, sck_oe, tx_wr = 1'b0, tx_empty, txd;
  logic [7:0] tx_data = 8'd0, rx_data;
  logic       rx_rd = 1'b0, rx_full, rx_overrun;
  logic       loop = 1'b1, rxd_drv = 1'b0, rxd;
  assign rxd = loop ? txd : rxd_drv;

  sync_serial_xcvr uut (
    .clk(clk), .rst(rst), .clk_mode(clk_mode), .div_cfg(div_cfg),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .tx_wr(tx_wr),
    .tx_data(tx_data), .tx_empty(tx_empty), .txd(txd), .rxd(rxd),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full),
    .rx_overrun(rx_overrun)
  );

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor of the internal serial clock, sampled on the falling system edge
  int         mon_bits = 0, hi_len = 0, lo_len = 0, last_lo = 0, char_gap = 0;
  int         r1_viol = 0;
  logic [7:0] mon_byte = 8'd0, hist0 = 8'd0, hist1 = 8'd0;
  logic       prev_sck = 1'b1, prev_txd = 1'b1;

  always @(negedge clk) begin
    if (!rst && !clk_mode[1]) begin
      if (!prev_sck && sck_o) begin
        mon_byte = {txd, mon_byte[7:1]};
        mon_bits++;
        if (mon_bits % 8 == 0) begin
          hist1 = hist0;
          hist0 = mon_byte;
        end
        last_lo = lo_len;
        hi_len  = 1;
      end else if (prev_sck && sck_o) begin
        hi_len++;
      end
      if (prev_sck && !sck_o) begin
        if (mon_bits % 8 == 0 && mon_bits > 0) char_gap = hi_len;
        lo_len = 1;
      end else if (!prev_sck && !sck_o) begin
        lo_len++;
      end
      if (!(prev_sck && !sck_o) && txd !== prev_txd) r1_viol++;
    end
    prev_sck = sck_o;
    prev_txd = txd;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] b);
    for (int t = 0; t < 400 && !tx_empty; t++) tick();
    tx_data = b;
    tx_wr   = 1'b1;
    tick();
    tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    rx_rd = 1'b1;
    tick();
    rx_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] a, b, c, rb, cap;
    int         d, sb;
    void'($urandom(32'h1234_5a5a));
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R11 reset state
    chk(tx_empty == 1'b1, "R11", "tx_empty", tx_empty, 1);
    chk(rx_full == 1'b0 && rx_overrun == 1'b0, "R11", "rx flags",
        {rx_full, rx_overrun}, 0);
    chk(sck_o == 1'b1 && sck_oe == 1'b1, "R11", "sck_o/sck_oe", {sck_o, sck_oe}, 3);
    chk(txd == 1'b1, "R4", "txd after reset", txd, 1);

    // Internal mode, loopback, random bytes and dividers
    for (int i = 0; i < 12; i++) begin
      d       = $urandom_range(0, 4);
      div_cfg = 8'(d);
      b       = 8'($urandom);
      if (i == 0) b = 8'h80;
      if (i == 1) b = 8'h01;
      sb = mon_bits;
      send(b);
      for (int t = 0; t < 200 && !rx_full; t++) tick();
      chk(rx_full == 1'b1, "R2", "rx_full after char", rx_full, 1);
      chk(rx_data == b, "R10", "loopback byte", rx_data, b);
      chk(hist0 == b, "R3", "LSB-first bit order on txd", hist0, b);
      chk(last_lo == d + 1, "R5", "low phase length", last_lo, d + 1);
      repeat (d + 4) tick();
      chk(sck_o == 1'b1, "R5", "clock idles high", sck_o, 1);
      chk(mon_bits - sb == 8, "R3", "pulses per char", mon_bits - sb, 8);
      chk(txd == b[7], "R4", "txd holds MSB", txd, b[7]);
      chk(tx_empty == 1'b1, "R7", "tx_empty after load", tx_empty, 1);
      read_rx();
      chk(rx_full == 1'b0, "R9", "rx_full cleared by read", rx_full, 0);
    end

    // Back-to-back, ignored write, overrun
    div_cfg = 8'd2;
    a = 8'($urandom);
    b = 8'($urandom);
    c = ~b;
    sb = mon_bits;
    send(a);
    for (int t = 0; t < 20 && !tx_empty; t++) tick();
    chk(tx_empty == 1'b1, "R7", "tx_empty after first fall", tx_empty, 1);
    tx_data = b;
    tx_wr = 1'b1;
    tick();
    tx_data = c;
    tick();
    tx_wr = 1'b0;
    for (int t = 0; t < 400 && mon_bits < sb + 16; t++) tick();
    repeat (12) tick();
    chk(mon_bits - sb == 16, "R7", "write while full ignored", mon_bits - sb, 16);
    chk(hist1 == a && hist0 == b, "R8", "chars in order", {hist1, hist0}, {a, b});
    chk(char_gap == 3, "R8", "high phase between chars", char_gap, 3);
    chk(rx_full && rx_data == a, "R9", "old byte kept", rx_data, a);
    chk(rx_overrun == 1'b1, "R9", "overrun set", rx_overrun, 1);
    read_rx();
    chk(rx_full == 1'b0 && rx_overrun == 1'b0, "R9", "read clears flags",
        {rx_full, rx_overrun}, 0);
    chk(r1_viol == 0, "R1", "txd change away from falling edge", r1_viol, 0);

    // External clock mode
    clk_mode = 2'b10;
    loop = 1'b0;
    repeat (3) tick();
    chk(sck_oe == 1'b0, "R6", "sck_oe in external mode", sck_oe, 0);
    for (int j = 0; j < 6; j++) begin
      b  = 8'($urandom);
      rb = 8'($urandom);
      send(b);
      for (int k = 0; k < 8; k++) begin
        sck_i   = 1'b0;
        rxd_drv = rb[k];
        repeat (6) tick();
        cap[k] = txd;
        sck_i  = 1'b1;
        repeat (6) tick();
      end
      chk(cap == b, "R6", "external tx bits", cap, b);
      chk(rx_full && rx_data == rb, "R6", "external rx byte", rx_data, rb);
      chk(txd == b[7], "R4", "txd holds MSB external", txd, b[7]);
      chk(sck_o == 1'b1, "R6", "internal clock quiet", sck_o, 1);
      read_rx();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule